// File: doc/BRIEF.md
# Serial Response Frame Receiver

This block collects one response frame from a remote target over a shared, single-wire, active-low data line once a command has gone out. It drives the serial clock itself. On a start request it lets go of the data line and sets the level-translator direction to input. It then clocks the line one bit per serial clock period and looks for a start bit. It gives up after a bounded number of periods. After the start bit it takes in a target id and a response tag. A payload of 1, 2 or 4 bytes follows only when the tag says acknowledge and the caller asked for data. A 4-bit check code closes the frame.

When the frame ends, or the hunt for a start bit runs out, the block raises a one-cycle completion pulse. In that same cycle it presents the id, the tag, the payload and two error flags: one for a missing response and one for a check-code mismatch. These outputs keep their values until the next start request is taken. Building commands and deciding whether to retry belong to the caller.

Top module: `rxf_receiver`

## Requirements
- R1: After reset the serial clock is high, the data line is driven (output enable 1, output level 1, translator direction 1), and busy and done are both 0.
- R2: A start request is taken only while busy is 0. It latches the size selector. A start request while busy is 1 has no effect on the frame in progress or on its results.
- R3: While busy is 1, the output enable and the translator direction are both 0. The serial clock runs with a period of 2*HALF_PERIOD clock cycles: it is low for the first half and high for the second. The line is sampled in the last cycle of the high half, and a low line reads as logical 1.
- R4: The receiver hunts for a logical-1 start bit. If START_TIMEOUT samples in a row read 0, it finishes with the timeout flag set, the tag at 0 and the data at 0. A start bit seen on sample START_TIMEOUT is still accepted. On timeout, done rises START_TIMEOUT*2*HALF_PERIOD+1 cycles after the cycle in which the start request was presented.
- R5: The 4 bits after the start bit are the id (first 2 bits, MSB first) and then the tag (next 2 bits, MSB first). Tag codes are: 0 acknowledge, 1 busy, 2 general error, 3 target-detected check error.
- R6: The size selector encodes the payload as 0 = none, 1 = 8 bits, 2 = 16 bits, 3 = 32 bits. A payload is read only when the tag is 0 and the size is not none. Otherwise the frame goes straight to the check code, and the data output is 0.
- R7: Payload bits arrive MSB first, so the first byte received becomes the most significant byte of the result. The result is zero-extended to 32 bits.
- R8: The check is CRC-4 with polynomial x^4+x+1, processed MSB first from a zero state. It runs over a leading 1 for the start bit, then the id, tag, payload and the 4 received check bits. Any nonzero remainder sets the check-error flag.
- R9: Done is a single-cycle pulse, and busy is 0 in that cycle. Id, tag, data and both error flags are updated with the pulse, hold until the next accepted start, and are cleared when that start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to receive one response frame |
| size_sel_i | input | 2 | Expected payload size code |
| line_in_i | input | 1 | Data line as seen at the pad (active low) |
| sclk_o | output | 1 | Serial clock toward the target |
| line_out_o | output | 1 | Level driven on the data line when enabled |
| line_oe_o | output | 1 | Data line output enable |
| xlat_dir_o | output | 1 | Level translator direction (1 = outward) |
| busy_o | output | 1 | Receive window active |
| done_o | output | 1 | One-cycle completion pulse |
| id_o | output | 2 | Target id from the frame |
| tag_o | output | 2 | Response tag |
| data_o | output | 32 | Received payload, first byte most significant |
| err_timeout_o | output | 1 | No start bit within the hunt window |
| err_crc_o | output | 1 | Check code remainder was nonzero |

## Verification
The bench sends frames with known field values and known check codes, so a wrong internal state shows up at the ports. A phase-counter fault moves the sample point or the serial clock period, which a one-period measurement catches within two clock edges of the line. A bit-counter or state fault shifts the field boundaries, so id, tag or payload come out skewed, or a busy-tagged frame is misread as carrying data. The check-code flag reports these at done, one frame length after start. A hunt-counter fault moves the timeout, and the exact cycle count checked at the 1000-sample boundary exposes it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HDR_BITS = 4;
  localparam int unsigned CRC_BITS = 4;
  localparam int unsigned CNT_W    = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    TAG_ACK  = 2'd0,
    TAG_BUSY = 2'd1,
    TAG_ERRA = 2'd2,
    TAG_ERRC = 2'd3
  } rsp_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_HDR,
    ST_DATA,
    ST_CRC
  } rx_state_e;

  function automatic logic [CNT_W-1:0] payload_bits(input logic [1:0] sel);
    case (sel)
      2'd1:    payload_bits = CNT_W'(8);
      2'd2:    payload_bits = CNT_W'(16);
      2'd3:    payload_bits = CNT_W'(32);
      default: payload_bits = '0;
    endcase
  endfunction

  // x^4 + x + 1, MSB-first, input folded into the feedback
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    crc4_step = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

endpackage

// File: rtl/rxf_bitclk.sv
module rxf_bitclk #(
  parameter int unsigned HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic tick_o
);
  localparam int unsigned PER = 2 * HALF_PERIOD;
  localparam int unsigned CW  = (PER > 1) ? $clog2(PER) : 1;

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
    end else if (phase_q == CW'(PER - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick_o = run_i && (phase_q == CW'(PER - 1));
  assign sclk_o = !run_i || (phase_q >= CW'(HALF_PERIOD));

endmodule

// File: rtl/rxf_crc4.sv
module rxf_crc4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic       bit_i,
  output logic [3:0] rem_nx_o
);
  import rxf_pkg::*;

  logic [3:0] rem_q;

  assign rem_nx_o = crc4_step(rem_q, bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (clear_i) begin
      rem_q <= '0;
    end else if (step_i) begin
      rem_q <= rem_nx_o;
    end
  end

endmodule

// File: rtl/rxf_hunt_timer.sv
module rxf_hunt_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned HW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [HW-1:0] zeros_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zeros_q <= '0;
    end else if (clear_i) begin
      zeros_q <= '0;
    end else if (step_i && !last_o) begin
      zeros_q <= zeros_q + 1'b1;
    end
  end

  // the sample in hand is the LIMIT-th empty one
  assign last_o = (zeros_q == HW'(LIMIT - 1));

endmodule

// File: rtl/rxf_receiver.sv
module rxf_receiver #(
  parameter int unsigned HALF_PERIOD   = 2,
  parameter int unsigned START_TIMEOUT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  size_sel_i,
  input  logic        line_in_i,
  output logic        sclk_o,
  output logic        line_out_o,
  output logic        line_oe_o,
  output logic        xlat_dir_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  id_o,
  output logic [1:0]  tag_o,
  output logic [31:0] data_o,
  output logic        err_timeout_o,
  output logic        err_crc_o
);
  import rxf_pkg::*;

  rx_state_e        st_q;
  logic [CNT_W-1:0] nbits_q;
  logic [CNT_W-1:0] bcnt_q;
  logic [2:0]       hdr_q;
  logic             tick;
  logic             bit_val;
  logic             accept;
  logic             hunt_last;
  logic [3:0]       rem_nx;
  logic             crc_step;
  logic [3:0]       hdr_full;

  assign busy_o     = (st_q != ST_IDLE);
  assign accept     = (st_q == ST_IDLE) && start_i;
  assign bit_val    = ~line_in_i;
  assign line_oe_o  = !busy_o;
  assign xlat_dir_o = !busy_o;
  assign line_out_o = 1'b1;
  assign hdr_full   = {hdr_q, bit_val};

  assign crc_step = tick && ((st_q == ST_HUNT) ? bit_val : busy_o);

  rxf_bitclk #(.HALF_PERIOD(HALF_PERIOD)) u_bitclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_o),
    .sclk_o (sclk_o),
    .tick_o (tick)
  );

  rxf_crc4 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .step_i   (crc_step),
    .bit_i    (bit_val),
    .rem_nx_o (rem_nx)
  );

  rxf_hunt_timer #(.LIMIT(START_TIMEOUT)) u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .step_i  (tick && (st_q == ST_HUNT) && !bit_val),
    .last_o  (hunt_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      nbits_q       <= '0;
      bcnt_q        <= '0;
      hdr_q         <= '0;
      done_o        <= 1'b0;
      id_o          <= '0;
      tag_o         <= '0;
      data_o        <= '0;
      err_timeout_o <= 1'b0;
      err_crc_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            nbits_q       <= payload_bits(size_sel_i);
            bcnt_q        <= '0;
            hdr_q         <= '0;
            id_o          <= '0;
            tag_o         <= '0;
            data_o        <= '0;
            err_timeout_o <= 1'b0;
            err_crc_o     <= 1'b0;
            st_q          <= ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (tick) begin
            if (bit_val) begin
              bcnt_q <= '0;
              st_q   <= ST_HDR;
            end else if (hunt_last) begin
              err_timeout_o <= 1'b1;
              done_o        <= 1'b1;
              st_q          <= ST_IDLE;
            end
          end
        end
        ST_HDR: begin
          if (tick) begin
            hdr_q <= hdr_full[2:0];
            if (bcnt_q == CNT_W'(HDR_BITS - 1)) begin
              id_o   <= hdr_full[3:2];
              tag_o  <= hdr_full[1:0];
              bcnt_q <= '0;
              if ((hdr_full[1:0] == TAG_ACK) && (nbits_q != '0)) begin
                st_q <= ST_DATA;
              end else begin
                st_q <= ST_CRC;
              end
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            data_o <= {data_o[DATA_W-2:0], bit_val};
            if (bcnt_q == nbits_q - 1'b1) begin
              bcnt_q <= '0;
              st_q   <= ST_CRC;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        ST_CRC: begin
          if (tick) begin
            if (bcnt_q == CNT_W'(CRC_BITS - 1)) begin
              err_crc_o <= (rem_nx != 4'd0);
              done_o    <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxf_receiver_chk.sv
module rxf_receiver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        sclk_o,
  input logic        line_oe_o,
  input logic        xlat_dir_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  id_o,
  input logic [1:0]  tag_o,
  input logic [31:0] data_o,
  input logic        err_timeout_o,
  input logic        err_crc_o
);

  a_r3_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!line_oe_o && !xlat_dir_o));

  a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(data_o) && $stable(tag_o) && $stable(id_o)
                               && $stable(err_timeout_o) && $stable(err_crc_o)));

  a_r4_errors_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(err_timeout_o && err_crc_o));

  a_r6_no_data_unless_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (tag_o != 2'd0)) |-> (data_o == 32'd0));

  a_r4_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_timeout_o) |-> ((data_o == 32'd0) && (tag_o == 2'd0)));

endmodule

bind rxf_receiver rxf_receiver_chk u_chk (.*);

// File: tb/rxf_receiver_bench.sv
module rxf_receiver_bench;
  localparam int HALF = 2;
  localparam int TMO  = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_sel_i = 2'd0;
  logic        line = 1'b1;
  logic        sclk_o, line_out_o, line_oe_o, xlat_dir_o, busy_o, done_o;
  logic [1:0]  id_o, tag_o;
  logic [31:0] data_o;
  logic        err_timeout_o, err_crc_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxf_receiver #(.HALF_PERIOD(HALF), .START_TIMEOUT(TMO)) u_rxf_receiver (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_sel_i(size_sel_i),
    .line_in_i(line), .sclk_o(sclk_o), .line_out_o(line_out_o),
    .line_oe_o(line_oe_o), .xlat_dir_o(xlat_dir_o), .busy_o(busy_o),
    .done_o(done_o), .id_o(id_o), .tag_o(tag_o), .data_o(data_o),
    .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc_bit(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

  task automatic wait_done();
    while (done_o !== 1'b1) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 sclk", sclk_o, 1);
    check("R1 oe", line_oe_o, 1);
    check("R1 level", line_out_o, 1);
    check("R1 xlat", xlat_dir_o, 1);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
  endtask

  // one frame: idle samples, start bit, id, tag, optional payload, check code
  task automatic run_frame(input string req, input logic [1:0] ssel, input int idle,
                           input logic [1:0] id, input logic [1:0] tg,
                           input logic [31:0] pl, input bit flip, input bit probe);
    logic frm [0:63];
    int n;
    int nb;
    logic [3:0] c;
    logic [31:0] exp_d;
    bit has;
    case (ssel)
      2'd1: nb = 8;
      2'd2: nb = 16;
      2'd3: nb = 32;
      default: nb = 0;
    endcase
    has = (tg == 2'd0) && (nb != 0);
    n = 0;
    frm[n++] = 1'b1;
    frm[n++] = id[1]; frm[n++] = id[0];
    frm[n++] = tg[1]; frm[n++] = tg[0];
    if (has) for (int i = nb - 1; i >= 0; i--) frm[n++] = pl[i];
    c = 4'd0;
    for (int i = 0; i < n; i++) c = crc_bit(c, frm[i]);
    if (flip) c[0] = ~c[0];
    for (int i = 3; i >= 0; i--) frm[n++] = c[i];
    exp_d = !has ? 32'd0 : (nb == 32) ? pl : (pl & ((32'd1 << nb) - 1));
    fork
      begin
        @(negedge clk); start_i = 1'b1; size_sel_i = ssel;
        @(negedge clk); start_i = 1'b0;
      end
      begin
        for (int i = 0; i < idle; i++) begin @(negedge sclk_o); line = 1'b1; end
        for (int i = 0; i < n; i++) begin @(negedge sclk_o); line = ~frm[i]; end
      end
      begin
        if (probe) begin
          int t0;
          @(negedge sclk_o); t0 = cyc;
          @(negedge sclk_o);
          check("R3 sclk period", cyc - t0, 2 * HALF);
          @(negedge clk);
          check("R3 oe released", line_oe_o, 0);
          check("R3 xlat input", xlat_dir_o, 0);
          check("R2 busy", busy_o, 1);
          start_i = 1'b1; size_sel_i = ~ssel;
          @(negedge clk); start_i = 1'b0;
        end
      end
    join
    wait_done();
    line = 1'b1;
    check({req, " id"}, id_o, id);
    check({req, " tag"}, tag_o, tg);
    check({req, " data"}, data_o, exp_d);
    check({req, " crc flag"}, err_crc_o, flip);
    check({req, " timeout flag"}, err_timeout_o, 0);
    @(negedge clk);
    check("R9 done single cycle", done_o, 0);
  endtask

  task automatic test_timeout();
    int c0;
    @(negedge clk); start_i = 1'b1; size_sel_i = 2'd3; c0 = cyc;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    check("R4 timeout flag", err_timeout_o, 1);
    check("R4 timeout latency", cyc - c0, TMO * 2 * HALF + 1);
    check("R4 timeout data", data_o, 0);
    check("R4 timeout crc flag", err_crc_o, 0);
  endtask

  task automatic test_hold();
    logic [31:0] d;
    logic [1:0] t;
    logic e;
    d = data_o; t = tag_o; e = err_crc_o;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); line = i[0];
    end
    line = 1'b1;
    check("R9 data held", data_o, d);
    check("R9 tag held", tag_o, t);
    check("R9 crc flag held", err_crc_o, e);
    check("R9 idle not busy", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_frame("R2 R5 R7 R8 ack4", 2'd3, 0, 2'd2, 2'd0, 32'hA5C3_0F96, 1'b0, 1'b1);
    run_frame("R7 ack1", 2'd1, 7, 2'd1, 2'd0, 32'h0000_005A, 1'b0, 1'b0);
    run_frame("R7 ack2", 2'd2, 3, 2'd3, 2'd0, 32'h0000_BEEF, 1'b0, 1'b0);
    run_frame("R6 ack none", 2'd0, 2, 2'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_frame("R6 busy tag", 2'd3, 1, 2'd1, 2'd1, 32'h1234_5678, 1'b0, 1'b0);
    run_frame("R5 erra", 2'd1, 0, 2'd2, 2'd2, 32'd0, 1'b0, 1'b0);
    run_frame("R5 errc", 2'd2, 4, 2'd3, 2'd3, 32'd0, 1'b0, 1'b0);
    run_frame("R8 bad check", 2'd2, 0, 2'd1, 2'd0, 32'h0000_C0DE, 1'b1, 1'b0);
    test_hold();
    run_frame("R4 late start", 2'd1, TMO - 1, 2'd2, 2'd0, 32'h0000_0081, 1'b0, 1'b0);
    test_timeout();
    test_hold();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule